// File: doc/BRIEF.md
# Multi-Format Conversion Result Memory

This block holds the results produced by a converter: 64 entries of 10 bits each. It has two write paths. The converter side stores each finished conversion in the entry whose index matches the command slot that asked for it. A 16-bit host bus reads and writes the same entries.

On a host read, the stored 10-bit value is placed on the 16-bit bus in one of three alignments. The host picks the alignment only through the address window it uses, so each entry can be reached at three aliased addresses. No mode register is involved.

- The right-justified view puts the value in the low bits.
- The two left-justified views put it in the high bits.
- One of the left-justified views also inverts the value's top bit. This turns a half-scale offset-binary code into two's complement.

Host writes always take right-justified data, whichever window they use.

Top module: `result_alias_mem`

## Requirements
- R1: After synchronous reset, every entry reads as 0 in every view, and `host_rvalid` is low.
- R2: A converter write (`cv_wr_en` high) stores `cv_data` at entry `cv_slot`. A later host read of that entry returns the stored value.
- R3: Window 00 (`host_addr[7:6]` = 2'b00) returns the entry in bits 9:0, with bits 15:10 at 0.
- R4: Window 01 returns the entry in bits 15:6, with the stored bit 9 inverted (bit 15 = NOT stored bit 9) and bits 5:0 at 0.
- R5: Window 10 returns the entry unchanged in bits 15:6, with bits 5:0 at 0.
- R6: Window 11 is reserved and always reads as 16'h0000.
- R7: A host write through window 00, 01 or 10 stores `host_wdata[9:0]` at entry `host_addr[5:0]`. Bits 15:10 of the write data are discarded.
- R8: A host write through window 11 changes no entry.
- R9: When the converter and the host write the same entry in the same cycle, the converter value is kept. When they write different entries, both writes take effect.
- R10: A read issued with `host_rd_en` in cycle N gives `host_rvalid` high and the data in cycle N+1. A read in the same cycle as a write to the same entry returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cv_wr_en | input | 1 | Converter write strobe |
| cv_slot | input | 6 | Command slot index of the finished conversion |
| cv_data | input | 10 | Conversion result |
| host_rd_en | input | 1 | Host read strobe |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 8 | Word address: [7:6] view window, [5:0] entry |
| host_wdata | input | 16 | Host write data, right-justified |
| host_rdata | output | 16 | Formatted read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
A wrong stored bit stays hidden until that entry is read. It then shows up one cycle after the read strobe, in all three views at once, shifted by the window's alignment. A wrong view decode shows as misplaced bits, as nonzero filler bits, or as a wrong sign bit in the same cycle as `host_rvalid`. A lost arbitration, or a write that should have been ignored, only shows on the next read of the affected entry. For that reason every write in the bench is followed at some point by reads through all windows.

// File: rtl/rmem_pkg.sv
package rmem_pkg;
    localparam int ENTRIES = 64;
    localparam int DATA_W  = 10;
    localparam int BUS_W   = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int VIEW_W  = 2;
    localparam int ADDR_W  = IDX_W + VIEW_W;
    localparam int PAD_W   = BUS_W - DATA_W;

    typedef enum logic [VIEW_W-1:0] {
        VIEW_RJ  = 2'b00,
        VIEW_LJS = 2'b01,
        VIEW_LJU = 2'b10,
        VIEW_RSV = 2'b11
    } view_e;

    typedef logic [DATA_W-1:0] entry_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        view_e view;
        idx_t  idx;
    } host_loc_t;

    typedef struct packed {
        view_e  view;
        entry_t data;
    } rd_token_t;

    function automatic logic [BUS_W-1:0] steer(input view_e v, input entry_t d);
        logic [BUS_W-1:0] w;
        w = '0;
        case (v)
            VIEW_RJ:  w[DATA_W-1:0] = d;
            VIEW_LJU: w[BUS_W-1 -: DATA_W] = d;
            VIEW_LJS: begin
                w[BUS_W-1 -: DATA_W] = d;
                w[BUS_W-1] = ~d[DATA_W-1];
            end
            default:  w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/rmem_decode.sv
module rmem_decode
    import rmem_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output host_loc_t         loc
);
    always_comb begin
        loc.view = view_e'(addr[ADDR_W-1 -: VIEW_W]);
        loc.idx  = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/rmem_array.sv
module rmem_array
    import rmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cv_we,
    input  idx_t      cv_idx,
    input  entry_t    cv_d,
    input  logic      h_we,
    input  host_loc_t h_loc,
    input  entry_t    h_d,
    input  logic      h_re,
    output rd_token_t rd_tok,
    output logic      rd_vld
);
    entry_t mem [ENTRIES];
    logic   h_commit;

    // Host write lands only outside the reserved window and when the converter
    // is not writing the same entry in this cycle.
    always_comb begin
        h_commit = h_we && (h_loc.view != VIEW_RSV) && !(cv_we && (cv_idx == h_loc.idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else begin
            if (h_commit) mem[h_loc.idx] <= h_d;
            if (cv_we)    mem[cv_idx]    <= cv_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld      <= 1'b0;
            rd_tok.view <= VIEW_RJ;
            rd_tok.data <= '0;
        end else begin
            rd_vld <= h_re;
            if (h_re) begin
                rd_tok.view <= h_loc.view;
                rd_tok.data <= mem[h_loc.idx];
            end
        end
    end

    p_conv_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (cv_we && h_we && cv_idx == h_loc.idx) |=> (mem[$past(cv_idx)] == $past(cv_d)));
    p_rsv_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (h_we && h_loc.view == VIEW_RSV && !(cv_we && cv_idx == h_loc.idx))
            |=> (mem[$past(h_loc.idx)] == $past(mem[h_loc.idx])));
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
        h_re |=> rd_vld);
    p_no_spurious_vld_r10: assert property (@(posedge clk) disable iff (rst)
        !h_re |=> !rd_vld);
endmodule

// File: rtl/rmem_format.sv
module rmem_format
    import rmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rd_token_t        tok,
    input  logic             vld,
    output logic [BUS_W-1:0] bus
);
    always_comb begin
        bus = steer(tok.view, tok.data);
    end

    p_rj_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (vld && tok.view == VIEW_RJ) |-> (bus[BUS_W-1:DATA_W] == '0));
    p_ljs_sign_r4: assert property (@(posedge clk) disable iff (rst)
        (vld && tok.view == VIEW_LJS) |-> (bus[BUS_W-1] != tok.data[DATA_W-1] && bus[PAD_W-1:0] == '0));
    p_lju_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (vld && tok.view == VIEW_LJU) |-> (bus[PAD_W-1:0] == '0));
    p_rsv_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (vld && tok.view == VIEW_RSV) |-> (bus == '0));
endmodule

// File: rtl/result_alias_mem.sv
module result_alias_mem
    import rmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cv_wr_en,
    input  logic [IDX_W-1:0]  cv_slot,
    input  logic [DATA_W-1:0] cv_data,
    input  logic              host_rd_en,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    output logic              host_rvalid
);
    host_loc_t loc;
    rd_token_t tok;
    logic      vld;

    rmem_decode u_dec (
        .addr (host_addr),
        .loc  (loc)
    );

    rmem_array u_arr (
        .clk    (clk),
        .rst    (rst),
        .cv_we  (cv_wr_en),
        .cv_idx (cv_slot),
        .cv_d   (cv_data),
        .h_we   (host_wr_en),
        .h_loc  (loc),
        .h_d    (host_wdata[DATA_W-1:0]),
        .h_re   (host_rd_en),
        .rd_tok (tok),
        .rd_vld (vld)
    );

    rmem_format u_fmt (
        .clk (clk),
        .rst (rst),
        .tok (tok),
        .vld (vld),
        .bus (host_rdata)
    );

    assign host_rvalid = vld;
endmodule

// File: tb/result_alias_mem_tb.sv
module result_alias_mem_tb;
    logic        clk = 0;
    logic        rst;
    logic        cv_wr_en, host_rd_en, host_wr_en;
    logic [5:0]  cv_slot;
    logic [9:0]  cv_data;
    logic [7:0]  host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic        host_rvalid;

    int checks = 0;
    int fails  = 0;
    logic [9:0] model [64];

    always #4 clk = ~clk;

    result_alias_mem u_dut (.*);

    function automatic logic [15:0] expect_view(input logic [1:0] w, input logic [9:0] v);
        if (w == 2'd0) return {6'd0, v};
        if (w == 2'd1) return {v ^ 10'h200, 6'd0};
        if (w == 2'd2) return {v, 6'd0};
        return 16'd0;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check read result at following negedge
    task automatic step(input logic cve, input logic [5:0] cs, input logic [9:0] cd,
                        input logic we, input logic re, input logic [7:0] a,
                        input logic [15:0] wd, input string req);
        logic [15:0] exp;
        exp = expect_view(a[7:6], model[a[5:0]]);
        cv_wr_en = cve; cv_slot = cs; cv_data = cd;
        host_wr_en = we; host_rd_en = re; host_addr = a; host_wdata = wd;
        @(negedge clk);
        check({req, " rvalid"}, {15'd0, host_rvalid}, {15'd0, re});
        if (re) check(req, host_rdata, exp);
        if (we && a[7:6] != 2'd3 && !(cve && cs == a[5:0])) model[a[5:0]] = wd[9:0];
        if (cve) model[cs] = cd;
        cv_wr_en = 0; host_wr_en = 0; host_rd_en = 0;
    endtask

    task automatic rd(input logic [1:0] w, input logic [5:0] i, input string req);
        step(0, 0, 0, 0, 1, {w, i}, 16'd0, req);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        for (int i = 0; i < 64; i++) model[i] = '0;
        cv_wr_en = 0; host_rd_en = 0; host_wr_en = 0;
        cv_slot = 0; cv_data = 0; host_addr = 0; host_wdata = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 rvalid in reset", {15'd0, host_rvalid}, 16'd0);
        rst = 0;
        // R1: reset contents
        for (int w = 0; w < 4; w++) rd(w[1:0], 6'd63, "R1");
        rd(2'd1, 6'd0, "R1");

        // R2/R3/R4/R5/R6: converter write then all views
        step(1, 6'd5, 10'h3A5, 0, 0, 8'd0, 16'd0, "R2");
        rd(2'd0, 6'd5, "R3");
        rd(2'd1, 6'd5, "R4");
        rd(2'd2, 6'd5, "R5");
        rd(2'd3, 6'd5, "R6");
        step(1, 6'd6, 10'h000, 0, 0, 8'd0, 16'd0, "R2");
        rd(2'd1, 6'd6, "R4 zero code");
        step(1, 6'd7, 10'h200, 0, 0, 8'd0, 16'd0, "R2");
        rd(2'd1, 6'd7, "R4 half scale");

        // R7: host write upper bits discarded, every window
        step(0, 0, 0, 1, 0, {2'd0, 6'd10}, 16'hFFFF, "R7");
        rd(2'd0, 6'd10, "R7 window00");
        step(0, 0, 0, 1, 0, {2'd1, 6'd11}, 16'hA955, "R7");
        rd(2'd0, 6'd11, "R7 window01");
        step(0, 0, 0, 1, 0, {2'd2, 6'd12}, 16'h7C01, "R7");
        rd(2'd2, 6'd12, "R7 window10");

        // R8: reserved window write ignored
        step(0, 0, 0, 1, 0, {2'd3, 6'd10}, 16'h0123, "R8");
        rd(2'd0, 6'd10, "R8");

        // R9: collision and parallel writes
        step(1, 6'd20, 10'h155, 1, 0, {2'd0, 6'd20}, 16'h02AA, "R9");
        rd(2'd0, 6'd20, "R9 converter wins");
        step(1, 6'd21, 10'h0F0, 1, 0, {2'd2, 6'd22}, 16'h030F, "R9");
        rd(2'd0, 6'd21, "R9 both cv");
        rd(2'd0, 6'd22, "R9 both host");

        // R10: read during write returns old data
        step(0, 0, 0, 1, 1, {2'd0, 6'd10}, 16'h0042, "R10 rdw host");
        rd(2'd0, 6'd10, "R10 new value");
        step(1, 6'd5, 10'h001, 0, 1, {2'd2, 6'd5}, 16'd0, "R10 rdw conv");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], (r[1] ? 6'($urandom) : {4'd0, r[3:2]}), 10'($urandom),
                 r[4], r[5] | r[6], {r[8:7], (r[9] ? 6'($urandom) : {4'd0, r[11:10]})},
                 16'($urandom), "R2/R7/R9/R10 random");
        end
        for (int i = 0; i < 64; i++) rd(2'($urandom), i[5:0], "R3/R4/R5 sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule